// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is the arithmetic and logic stage of a simple load/store processor datapath. It receives a 2-bit instruction-class code from the main controller and the 6-bit function field of the current instruction. A local decoder turns these two inputs into a 3-bit operation code. A 32-bit execution unit then applies that operation to two operands and returns a result and a zero flag. The branch logic uses the zero flag to test two registers for equality.

The block has no clock and holds no state. Its outputs change in the same cycle as its inputs. The operation code uses a sparse encoding: five of its eight values name real operations, and one further value marks a request the decoder does not recognise. The block exports the operation code so that neighbouring logic and tests can see which operation was selected.

Top module: `alu2l_top`

## Requirements
- R1: The `op_o` encodings are fixed: 000 is AND, 001 is OR, 010 is add, 110 is subtract, 111 is signed set-on-less-than, and 011 means the request was not recognised.
- R2: Class 00 (memory reference) selects add and class 01 (branch compare) selects subtract, whatever the function field holds.
- R3: Class 10 (register-register) decodes the function field as follows: 0x20 gives add, 0x22 gives subtract, 0x24 gives AND, 0x25 gives OR, and 0x2A gives set-on-less-than.
- R4: Class 11, or class 10 with any other function value, sets `op_o` to 011 and forces `result_o` to zero.
- R5: Add and subtract wrap modulo 2^32 and raise no flag.
- R6: AND and OR act bit by bit on the two operands.
- R7: Set-on-less-than compares the operands as signed two's-complement values. It returns 1 in bit 0 when A < B, otherwise 0, and every upper bit is 0.
- R8: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R9: The block is purely combinational: outputs follow a change of input with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 2 | Instruction class from the main controller |
| funct_i | input | 6 | Function field of the instruction |
| opnd_a_i | input | 32 | First operand |
| opnd_b_i | input | 32 | Second operand |
| op_o | output | 3 | Decoded operation code |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The bench sweeps all 256 combinations of class and function value. This catches a decoder that lets the function field override the memory or branch class, or that maps an unknown function value to a real operation instead of the reserved code with a zero result.

Signed compares are tested with operands whose sign bits differ. These include the most negative value against the most positive value, and minus one against zero. An unsigned comparator, or a sign test that ignores overflow, gives the inverted answer on these pairs.

Add and subtract are driven across the 2^31 boundary and the 2^32 boundary. Results that wrap to zero check that the zero flag follows the whole result and not only the low bits.

// File: rtl/alu2l_pkg.sv
package alu2l_pkg;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_RSV = 3'b011,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_MEM   = 2'b00,
      CLS_BR    = 2'b01,
      CLS_RTYPE = 2'b10,
      CLS_RSV   = 2'b11
   } alu_cls_e;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu2l_decode.sv
module alu2l_decode
   import alu2l_pkg::*;
#(
   parameter int FUNCT_W = 6
) (
   input  logic [1:0]         cls_i,
   input  logic [FUNCT_W-1:0] funct_i,
   output alu_op_e            op_o
);

   localparam int CODE_W = 6;

   if (FUNCT_W < CODE_W) begin : g_bad_funct_w
      $error("alu2l_decode: FUNCT_W must be at least 6");
   end

   logic hi_clear;

   if (FUNCT_W > CODE_W) begin : g_wide_funct
      assign hi_clear = ~|funct_i[FUNCT_W-1:CODE_W];
   end else begin : g_exact_funct
      assign hi_clear = 1'b1;
   end

   logic [CODE_W-1:0] code;
   assign code = funct_i[CODE_W-1:0];

   always_comb begin
      op_o = ALU_RSV;
      case (cls_i)
         CLS_MEM: op_o = ALU_ADD;
         CLS_BR:  op_o = ALU_SUB;
         CLS_RTYPE: begin
            if (hi_clear) begin
               case (code)
                  FN_ADD:  op_o = ALU_ADD;
                  FN_SUB:  op_o = ALU_SUB;
                  FN_AND:  op_o = ALU_AND;
                  FN_OR:   op_o = ALU_OR;
                  FN_SLT:  op_o = ALU_SLT;
                  default: op_o = ALU_RSV;
               endcase
            end
         end
         default: op_o = ALU_RSV;
      endcase
   end

endmodule

// File: rtl/alu2l_arith.sv
module alu2l_arith #(
   parameter int DATA_W      = 32,
   parameter bit SLT_VIA_SUB = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              lt_o
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("alu2l_arith: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] b_eff;
   assign b_eff = sub_i ? ~b_i : b_i;
   assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};

   if (SLT_VIA_SUB) begin : g_slt_shared
      // The compare reuses the subtractor. The owner must hold sub_i high for SLT.
      logic ovf;
      assign ovf  = (a_i[MSB] != b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
      assign lt_o = sum_o[MSB] ^ ovf;
   end else begin : g_slt_direct
      assign lt_o = $signed(a_i) < $signed(b_i);
   end

endmodule

// File: rtl/alu2l_zero.sv
module alu2l_zero #(
   parameter int DATA_W = 32,
   parameter int SLICE  = 8
) (
   input  logic [DATA_W-1:0] val_i,
   output logic              zero_o
);

   localparam int NSLICE = (DATA_W + SLICE - 1) / SLICE;
   localparam int PAD_W  = NSLICE * SLICE;

   if (SLICE < 1) begin : g_bad_slice
      $error("alu2l_zero: SLICE must be positive");
   end

   logic [PAD_W-1:0]  padded;
   logic [NSLICE-1:0] slice_any;

   assign padded = {{(PAD_W-DATA_W){1'b0}}, val_i};

   for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      assign slice_any[s] = |padded[s*SLICE +: SLICE];
   end

   assign zero_o = ~|slice_any;

endmodule

// File: rtl/alu2l_top.sv
module alu2l_top
   import alu2l_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int FUNCT_W     = 6,
   parameter bit SLT_VIA_SUB = 1'b1,
   parameter int ZERO_SLICE  = 8
) (
   input  logic [1:0]         cls_i,
   input  logic [FUNCT_W-1:0] funct_i,
   input  logic [DATA_W-1:0]  opnd_a_i,
   input  logic [DATA_W-1:0]  opnd_b_i,
   output logic [2:0]         op_o,
   output logic [DATA_W-1:0]  result_o,
   output logic               zero_o
);

   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_data_w
      $error("alu2l_top: DATA_W must be at least 2");
   end

   alu_op_e           op_w;
   logic              sub_w;
   logic [DATA_W-1:0] sum_w;
   logic              lt_w;

   alu2l_decode #(.FUNCT_W(FUNCT_W)) i_decode (
      .cls_i   (cls_i),
      .funct_i (funct_i),
      .op_o    (op_w)
   );

   assign sub_w = (op_w == ALU_SUB) || (op_w == ALU_SLT);

   alu2l_arith #(.DATA_W(DATA_W), .SLT_VIA_SUB(SLT_VIA_SUB)) i_arith (
      .a_i   (opnd_a_i),
      .b_i   (opnd_b_i),
      .sub_i (sub_w),
      .sum_o (sum_w),
      .lt_o  (lt_w)
   );

   always_comb begin
      case (op_w)
         ALU_AND: result_o = opnd_a_i & opnd_b_i;
         ALU_OR:  result_o = opnd_a_i | opnd_b_i;
         ALU_ADD,
         ALU_SUB: result_o = sum_w;
         ALU_SLT: result_o = {{MSB{1'b0}}, lt_w};
         default: result_o = '0;
      endcase
   end

   alu2l_zero #(.DATA_W(DATA_W), .SLICE(ZERO_SLICE)) i_zero (
      .val_i  (result_o),
      .zero_o (zero_o)
   );

   assign op_o = op_w;

   // Guards on the settled combinational outputs
   always_comb begin
      if (op_w == ALU_SLT) begin
         p_slt_upper_clear_r7: assert (result_o[MSB:1] == '0)
            else $error("SLT result has upper bits set");
      end
      if (op_w == ALU_RSV) begin
         p_reserved_zero_r4: assert (result_o == '0 && zero_o)
            else $error("reserved op produced a nonzero result");
      end
      if (cls_i == CLS_BR) begin
         p_branch_sub_r2: assert (op_w == ALU_SUB)
            else $error("branch class did not select subtract");
      end
      if (op_w == ALU_SUB && zero_o) begin
         p_equal_on_zero_r8: assert (opnd_a_i == opnd_b_i)
            else $error("zero flag on subtract with unequal operands");
      end
      if (cls_i == CLS_MEM) begin
         p_mem_add_r2: assert (op_w == ALU_ADD)
            else $error("memory class did not select add");
      end
   end

endmodule

// File: tb/test_alu2l_top.sv
module test_alu2l_top;

   typedef struct {
      logic [2:0]  op;
      logic [31:0] res;
      logic        z;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  cls = 2'b00;
   logic [5:0]  funct = 6'h00;
   logic [31:0] opa = 32'h0;
   logic [31:0] opb = 32'h0;
   logic [2:0]  op_o;
   logic [31:0] result_o;
   logic        zero_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   alu2l_top i_alu2l_top (
      .cls_i    (cls),
      .funct_i  (funct),
      .opnd_a_i (opa),
      .opnd_b_i (opb),
      .op_o     (op_o),
      .result_o (result_o),
      .zero_o   (zero_o)
   );

   // Reference model written from the requirements
   function automatic exp_t model(logic [1:0] c, logic [5:0] f, logic [31:0] a, logic [31:0] b, string tag);
      exp_t e;
      logic [2:0] op;
      if (c == 2'b00)      op = 3'b010;
      else if (c == 2'b01) op = 3'b110;
      else if (c == 2'b10) begin
         if (f == 6'h20)      op = 3'b010;
         else if (f == 6'h22) op = 3'b110;
         else if (f == 6'h24) op = 3'b000;
         else if (f == 6'h25) op = 3'b001;
         else if (f == 6'h2A) op = 3'b111;
         else                 op = 3'b011;
      end else op = 3'b011;
      e.op = op;
      if (op == 3'b000)      e.res = a & b;
      else if (op == 3'b001) e.res = a | b;
      else if (op == 3'b010) e.res = a + b;
      else if (op == 3'b110) e.res = a - b;
      else if (op == 3'b111) e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      else                   e.res = 32'd0;
      e.z = (e.res == 32'd0);
      e.tag = tag;
      return e;
   endfunction

   function automatic void compare(exp_t e);
      checks++;
      if (op_o !== e.op || result_o !== e.res || zero_o !== e.z) begin
         fails++;
         $display("FAIL %s: actual op=%b res=%h zero=%b expected op=%b res=%h zero=%b",
                  e.tag, op_o, result_o, zero_o, e.op, e.res, e.z);
      end
   endfunction

   task automatic drive(logic [1:0] c, logic [5:0] f, logic [31:0] a, logic [31:0] b, string tag);
      @(posedge clk);
      #1;
      cls = c; funct = f; opa = a; opb = b;
      sb_q.push_back(model(c, f, a, b, tag));
   endtask

   // Monitor: one result per cycle, sampled on the falling edge
   always @(negedge clk) begin
      if (!rst && sb_q.size() > 0) compare(sb_q.pop_front());
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Idle inputs: class 00 on zero operands gives add with a zero result (R2, R8)
      drive(2'b00, 6'h00, 32'h0, 32'h0, "R2 idle");

      // R9: the outputs follow an input change with no clock edge
      @(negedge clk);
      #1;
      cls = 2'b10; funct = 6'h25; opa = 32'hA000_0000; opb = 32'h0000_0005;
      #1;
      compare(model(2'b10, 6'h25, 32'hA000_0000, 32'h0000_0005, "R9 no-edge"));

      // R1, R2, R3, R4: sweep every class and function value
      for (int c = 0; c < 4; c++) begin
         for (int f = 0; f < 64; f++) begin
            string t;
            if (c < 2)       t = "R2 class";
            else if (c == 3) t = "R4 reserved class";
            else if (f == 'h20 || f == 'h22 || f == 'h24 || f == 'h25 || f == 'h2A)
                             t = "R3 funct";
            else             t = "R4 unknown funct";
            drive(c[1:0], f[5:0], 32'hF0F0_1234, 32'h0FF0_4321, t);
         end
      end

      // R1: each encoding shown directly
      drive(2'b10, 6'h24, 32'hFFFF_0000, 32'h00FF_FF00, "R1 AND code");
      drive(2'b10, 6'h25, 32'hFFFF_0000, 32'h00FF_FF00, "R1 OR code");
      drive(2'b10, 6'h2A, 32'h1, 32'h2, "R1 SLT code");

      // R5: wrap-around
      drive(2'b00, 6'h00, 32'h7FFF_FFFF, 32'h1, "R5 add past 2^31");
      drive(2'b10, 6'h20, 32'hFFFF_FFFF, 32'h1, "R5 add wraps to zero");
      drive(2'b10, 6'h22, 32'h0, 32'h1, "R5 sub below zero");
      drive(2'b01, 6'h3F, 32'h8000_0000, 32'h1, "R5 sub past -2^31");

      // R6: bitwise patterns
      drive(2'b10, 6'h24, 32'hAAAA_5555, 32'h5555_AAAA, "R6 AND disjoint");
      drive(2'b10, 6'h25, 32'hAAAA_5555, 32'h5555_AAAA, "R6 OR fill");
      drive(2'b10, 6'h24, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R6 AND mask");

      // R7: signed compares
      drive(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, "R7 min<max");
      drive(2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, "R7 max<min");
      drive(2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h0, "R7 -1<0");
      drive(2'b10, 6'h2A, 32'h0, 32'hFFFF_FFFF, "R7 0<-1");
      drive(2'b10, 6'h2A, 32'h1234_5678, 32'h1234_5678, "R7 equal");
      drive(2'b10, 6'h2A, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R7 -2<-1");

      // R8: zero flag from equal operands and high-only results
      drive(2'b01, 6'h00, 32'hCAFE_F00D, 32'hCAFE_F00D, "R8 branch equal");
      drive(2'b01, 6'h00, 32'h8000_0000, 32'h0, "R8 high bit only");
      drive(2'b10, 6'h24, 32'hF000_0000, 32'h0F00_0000, "R8 AND to zero");

      while (sb_q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule